// File: doc/BRIEF.md
# I2C Line Control Register

This block is a single byte-wide control and status register that sits beside an I2C transfer engine. Software uses it to look at the SDA and SCL line levels, to hold either line low or let it go through open-drain drive controls, and to ask for one extra SCL clock pulse, for example to free a slave that is stuck holding SDA. The same byte also enables the pin drivers and puts the interface into reset.

The pin inputs are combined with the block's own drive before a two-flop synchronizer. The monitor bits therefore show the levels that the block forces, as a downstream start detector would see them. An extra-clock request is passed to the SCL clock generator through a request/grant pair. Once granted, the block drives SCL low for `PHASE_CYC` system clocks and then releases it for `PHASE_CYC` clocks, after which the request bit clears itself. If software changes the line drive while the transfer engine reports busy, the write still takes effect and a sticky flag is raised.

Top module: `i2c_linectl`

## Requirements
- R1: After reset, a read at address `REG_ADDR` returns 0x1F. A read at any other address returns 0x00, and a write at any other address changes nothing.
- R2: Bit 0 reports the SDA level and bit 1 reports the SCL level, where level = pin input AND NOT own drive. A pin change becomes visible after the second rising clock edge and not after the first.
- R3: Bit 2 is the SDA drive latch and bit 3 is the SCL drive latch (0 = hold low, 1 = release). A write loads them only if bit 4 of the same write data is 0. Bit 4 always reads as 1.
- R4: `sda_oe` (1 = pull low) equals bit 7 AND NOT bit 2, and `scl_oe` equals bit 7 AND (NOT bit 3 OR extra-pulse low phase). With bit 7 at 0, both lines are released.
- R5: Writing 1 to bit 5 sets it and raises `xclk_req` while bit 7 is 1. One rising edge after `xclk_gnt` is seen, SCL is driven low for exactly `PHASE_CYC` cycles and then released for `PHASE_CYC` cycles. Bit 5 then reads 0, so bit 5 reads 1 for 2·`PHASE_CYC`+1 cycles after the write when the grant is already present. Writing 0 to bit 5 has no effect.
- R6: A write with bit 6 set returns bits 2 and 3 to 1, clears bit 5, stops any extra pulse at once and asserts `bitcnt_clr` for as long as bit 6 stays 1.
- R7: A write with bit 6 = 1 and bit 7 = 0 (full reset) also clears `unsafe_wr`. With bit 7 = 1 (internal reset only), `unsafe_wr` is kept.
- R8: `unsafe_wr` becomes 1 when a write loads bits 2/3 while `xfer_busy` is 1. It stays 1 until reset or a full reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Register bus address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| sda_in | input | 1 | SDA pin level |
| scl_in | input | 1 | SCL pin level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| xclk_req | output | 1 | Extra-pulse request to clock generator |
| xclk_gnt | input | 1 | Clock generator grant |
| xfer_busy | input | 1 | Transfer engine busy |
| bitcnt_clr | output | 1 | Clears the bit counter while internal reset is held |
| unsafe_wr | output | 1 | Sticky flag for line writes made during a transfer |

## Verification
The bench walks all 256 write values while varying the busy input. Each result is checked against an arithmetic model of the protect, reset and enable rules. A design that stored the protect bit, or that ignored its gating, would show latch values that differ from the model. Pulse tests count the driven-low cycles and the cycles during which bit 5 stays set. These counts catch an off-by-one phase counter or a bit that clears early. Further checks cover an abort part-way through a pulse, the exact synchronizer latency, and the difference between full reset and internal reset for the sticky flag.

// File: rtl/i2c_linectl_pkg.sv
package i2c_linectl_pkg;
  localparam int unsigned B_SDA_MON = 0;
  localparam int unsigned B_SCL_MON = 1;
  localparam int unsigned B_SDA_LAT = 2;
  localparam int unsigned B_SCL_LAT = 3;
  localparam int unsigned B_PROT    = 4;
  localparam int unsigned B_XCLK    = 5;
  localparam int unsigned B_IRST    = 6;
  localparam int unsigned B_EN      = 7;

  typedef enum logic [1:0] {
    XC_IDLE = 2'd0,
    XC_LOW  = 2'd1,
    XC_HIGH = 2'd2
  } xclk_state_e;
endpackage

// File: rtl/i2c_linectl_sync.sv
module i2c_linectl_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], d[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL}};
      else        sh_q <= sh_d;
    end

    assign q[g] = sh_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_linectl_xclk.sv
module i2c_linectl_xclk
  import i2c_linectl_pkg::*;
#(
  parameter int unsigned PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic req,
  input  logic gnt,
  output logic low,
  output logic done
);
  localparam int unsigned CNT_W = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PHASE_CYC - 1);

  xclk_state_e st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      XC_IDLE: if (req && gnt) begin
        st_d  = XC_LOW;
        cnt_d = '0;
      end
      XC_LOW: if (cnt_q == LAST) begin
        st_d  = XC_HIGH;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      XC_HIGH: if (cnt_q == LAST) begin
        st_d  = XC_IDLE;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      default: begin
        st_d  = XC_IDLE;
        cnt_d = '0;
      end
    endcase
    if (clr) begin
      st_d  = XC_IDLE;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= XC_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign low  = (st_q == XC_LOW);
  assign done = (st_q == XC_HIGH) && (cnt_q == LAST);

  // R5: phase counter never passes the programmed phase length
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5: low phase is always followed by the high phase
  a_r5_low_then_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == XC_LOW && cnt_q == LAST && !clr) |=> (st_q == XC_HIGH));

  // R6: clear always parks the generator
  a_r6_clr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (st_q == XC_IDLE));
endmodule

// File: rtl/i2c_linectl_regs.sv
module i2c_linectl_regs
  import i2c_linectl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc,
  input  logic [7:0] wdata,
  input  logic       xfer_busy,
  input  logic       done,
  output logic       en,
  output logic       irst,
  output logic       sda_lat,
  output logic       scl_lat,
  output logic       xreq,
  output logic       unsafe,
  output logic       rst_eff
);
  logic en_q, en_d, irst_q, irst_d;
  logic sda_q, sda_d, scl_q, scl_d;
  logic xreq_q, xreq_d, uns_q, uns_d;
  logic en_eff, full_eff, lat_ld;

  always_comb begin
    rst_eff  = acc ? wdata[B_IRST] : irst_q;
    en_eff   = acc ? wdata[B_EN]   : en_q;
    full_eff = rst_eff && !en_eff;
    lat_ld   = acc && !wdata[B_PROT] && !rst_eff;

    en_d   = en_eff;
    irst_d = rst_eff;
    sda_d  = sda_q;
    scl_d  = scl_q;
    xreq_d = xreq_q;
    uns_d  = uns_q;

    if (rst_eff) begin
      sda_d  = 1'b1;
      scl_d  = 1'b1;
      xreq_d = 1'b0;
      if (full_eff) uns_d = 1'b0;
    end else begin
      if (lat_ld) begin
        sda_d = wdata[B_SDA_LAT];
        scl_d = wdata[B_SCL_LAT];
        if (xfer_busy) uns_d = 1'b1;
      end
      if (acc && wdata[B_XCLK]) xreq_d = 1'b1;
      else if (done)            xreq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      irst_q <= 1'b0;
      sda_q  <= 1'b1;
      scl_q  <= 1'b1;
      xreq_q <= 1'b0;
      uns_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      irst_q <= irst_d;
      sda_q  <= sda_d;
      scl_q  <= scl_d;
      xreq_q <= xreq_d;
      uns_q  <= uns_d;
    end
  end

  assign en      = en_q;
  assign irst    = irst_q;
  assign sda_lat = sda_q;
  assign scl_lat = scl_q;
  assign xreq    = xreq_q;
  assign unsafe  = uns_q;

  // R3: a protected write leaves both drive latches untouched
  a_r3_protect: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && wdata[B_PROT] && !wdata[B_IRST]) |=> ($stable(sda_q) && $stable(scl_q)));

  // R6: while internal reset is held, latches are released and no request pends
  a_r6_reset_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irst_q |-> (sda_q && scl_q && !xreq_q));

  // R5: the request bit only drops after a finished pulse or a reset
  a_r5_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xreq_q) |-> ($past(done) || $past(rst_eff)));

  // R7: the sticky flag survives anything but a full reset
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uns_q && !(acc && wdata[B_IRST] && !wdata[B_EN])) |=> uns_q);
endmodule

// File: rtl/i2c_linectl.sv
module i2c_linectl
  import i2c_linectl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0,
  parameter int unsigned PHASE_CYC = 4,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              sda_in,
  input  logic              scl_in,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic              xclk_req,
  input  logic              xclk_gnt,
  input  logic              xfer_busy,
  output logic              bitcnt_clr,
  output logic              unsafe_wr
);
  logic sel, acc;
  logic en, irst, sda_lat, scl_lat, xreq, unsafe, rst_eff;
  logic xc_low, xc_done;
  logic [1:0] line_raw, line_mon;

  assign sel = (reg_addr == REG_ADDR);
  assign acc = sel && reg_wr;

  i2c_linectl_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .wdata     (reg_wdata),
    .xfer_busy (xfer_busy),
    .done      (xc_done),
    .en        (en),
    .irst      (irst),
    .sda_lat   (sda_lat),
    .scl_lat   (scl_lat),
    .xreq      (xreq),
    .unsafe    (unsafe),
    .rst_eff   (rst_eff)
  );

  i2c_linectl_xclk #(.PHASE_CYC(PHASE_CYC)) u_xclk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (rst_eff),
    .req   (xclk_req),
    .gnt   (xclk_gnt),
    .low   (xc_low),
    .done  (xc_done)
  );

  assign xclk_req   = xreq && en;
  assign sda_oe     = en && !sda_lat;
  assign scl_oe     = en && (!scl_lat || xc_low);
  assign bitcnt_clr = irst;
  assign unsafe_wr  = unsafe;

  assign line_raw[0] = sda_in && !sda_oe;
  assign line_raw[1] = scl_in && !scl_oe;

  i2c_linectl_sync #(.WIDTH(2), .STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (line_raw),
    .q     (line_mon)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel) begin
      reg_rdata[B_SDA_MON] = line_mon[0];
      reg_rdata[B_SCL_MON] = line_mon[1];
      reg_rdata[B_SDA_LAT] = sda_lat;
      reg_rdata[B_SCL_LAT] = scl_lat;
      reg_rdata[B_PROT]    = 1'b1;
      reg_rdata[B_XCLK]    = xreq;
      reg_rdata[B_IRST]    = irst;
      reg_rdata[B_EN]      = en;
    end
  end

  // R5: an extra pulse only drives SCL while a request is outstanding
  a_r5_low_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    xc_low |-> xreq);
endmodule

// File: tb/i2c_linectl_tb.sv
`timescale 1ns/1ps
module i2c_linectl_tb;
  localparam int P = 4;
  localparam logic [3:0] RA = 4'h0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] reg_addr = RA;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic sda_in = 1'b1, scl_in = 1'b1;
  logic sda_oe, scl_oe, xclk_req, bitcnt_clr, unsafe_wr;
  logic xclk_gnt = 1'b0, xfer_busy = 1'b0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  i2c_linectl #(.ADDR_W(4), .REG_ADDR(RA), .PHASE_CYC(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
    .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe), .xclk_req(xclk_req),
    .xclk_gnt(xclk_gnt), .xfer_busy(xfer_busy), .bitcnt_clr(bitcnt_clr),
    .unsafe_wr(unsafe_wr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = RA;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic e_en, e_rst, e_sda, e_scl, e_xr, e_uns, busy, soe, coe;
    int lowc, setc, monc;
    idle(2);
    rst_n = 1'b1;
    idle(2);
    // R1 reset value and address decode
    chk("R1 reset value", reg_rdata, 8'h1F);
    reg_addr = 4'h5;
    @(negedge clk);
    chk("R1 other address reads zero", reg_rdata, 0);
    reg_addr = RA;
    wr(4'h5, 8'h80);
    idle(1);
    chk("R1 other address write ignored", reg_rdata, 8'h1F);

    // Sweep of every write value: R3 R4 R6 R7 R8
    e_en = 0; e_rst = 0; e_sda = 1; e_scl = 1; e_xr = 0; e_uns = 0;
    for (int v = 0; v < 256; v++) begin
      logic [7:0] w;
      w = 8'(v);
      busy = (v % 3 == 0);
      xfer_busy = busy;
      wr(RA, w);
      if (w[6]) begin
        e_sda = 1; e_scl = 1; e_xr = 0;
        if (!w[7]) e_uns = 0;
      end else begin
        if (!w[4]) begin
          e_sda = w[2]; e_scl = w[3];
          if (busy) e_uns = 1;
        end
        if (w[5]) e_xr = 1;
      end
      e_en = w[7]; e_rst = w[6];
      xfer_busy = 1'b0;
      idle(3);
      soe = e_en & ~e_sda;
      coe = e_en & ~e_scl;
      chk("R3 sweep readback", reg_rdata,
          {e_en, e_rst, e_xr, 1'b1, e_scl, e_sda, ~coe, ~soe});
      chk("R4 sweep sda_oe", sda_oe, soe);
      chk("R4 sweep scl_oe", scl_oe, coe);
      chk("R5 sweep xclk_req", xclk_req, e_xr & e_en);
      chk("R6 sweep bitcnt_clr", bitcnt_clr, e_rst);
      chk("R8 sweep unsafe", unsafe_wr, e_uns);
    end

    // R5 writing 0 does not cancel a request
    wr(RA, 8'h8C);
    wr(RA, 8'hAC);
    chk("R5 request set", reg_rdata[5], 1);
    chk("R5 xclk_req raised", xclk_req, 1);
    wr(RA, 8'h8C);
    chk("R5 zero write ignored", reg_rdata[5], 1);
    wr(RA, 8'hCC);
    chk("R6 reset clears request", reg_rdata[5], 0);

    // R5 one pulse, counted
    wr(RA, 8'h8C);
    xclk_gnt = 1'b1;
    wr(RA, 8'hAC);
    lowc = 0; setc = 0; monc = 0;
    for (int i = 0; i < 4 * P + 6; i++) begin
      if (scl_oe) lowc++;
      if (reg_rdata[5]) setc++;
      if (!reg_rdata[1]) monc++;
      @(negedge clk);
    end
    chk("R5 low phase length", lowc, P);
    chk("R5 request held cycles", setc, 2 * P + 1);
    chk("R2 monitor sees forced SCL low", monc, P);

    // R6 abort mid pulse
    wr(RA, 8'hAC);
    idle(1);
    chk("R5 pulse drives low", scl_oe, 1);
    wr(RA, 8'hCC);
    chk("R6 abort releases SCL", scl_oe, 0);
    chk("R6 abort clears request", reg_rdata[5], 0);
    chk("R6 bitcnt_clr held", bitcnt_clr, 1);
    xclk_gnt = 1'b0;

    // R2 synchronizer latency
    wr(RA, 8'h8C);
    idle(3);
    sda_in = 1'b0;
    @(negedge clk);
    chk("R2 one edge not yet seen", reg_rdata[0], 1);
    @(negedge clk);
    chk("R2 two edges seen", reg_rdata[0], 0);
    chk("R4 released line not driven", sda_oe, 0);
    sda_in = 1'b1;
    idle(3);

    // R7 / R8 sticky flag vs reset kind
    xfer_busy = 1'b1;
    wr(RA, 8'h80);
    xfer_busy = 1'b0;
    chk("R8 busy write flags", unsafe_wr, 1);
    chk("R4 latch low drives SDA", sda_oe, 1);
    wr(RA, 8'hC0);
    chk("R7 internal reset keeps flag", unsafe_wr, 1);
    chk("R6 internal reset releases SDA", sda_oe, 0);
    wr(RA, 8'h40);
    chk("R7 full reset clears flag", unsafe_wr, 0);
    idle(3);
    chk("R7 full reset readback", reg_rdata, 8'h5F);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule